// File: doc/BRIEF.md
# LCD Segment Refresh Scanner

This block drives the display side of a 64-column graphic LCD segment driver. Three slow panel-timing inputs arrive asynchronously and are brought into the internal clock: a frame marker, a line clock and an alternation phase. Every line period the block keeps a 6-bit line number and reads the matching row out of an 8-page by 64-column byte-wide display RAM. It holds the 64 row bits in a latch and turns each one into a 2-bit drive-level code for the analog level switches.

A frame marker presets the line number from a host-written start line, which scrolls the picture vertically. A falling line-clock edge advances the line number and starts a 64-read fetch of the next row. The rising line-clock edge moves the fetched row to the output latch and, in the same edge, samples the host's display-on request. A static orientation pin mirrors the column-to-segment order.

The fetch sequencer has three states. FS_IDLE waits. It goes to FS_READ on a line-clock fall. FS_READ issues one RAM read per cycle for columns 0 to 63. It goes to FS_DRAIN after column 63, or restarts at column 0 on a new line-clock fall. FS_DRAIN lets the last read return. It then goes to FS_IDLE, or to FS_READ on a line-clock fall.

Top module: `seg_scan_top`

## Requirements
- R1: While the synchronised frame marker is high, the line number is loaded with `start_line_in` every cycle. This takes priority over a line-clock fall in the same cycle.
- R2: With the frame marker low, each line-clock falling edge adds one to the line number, and 63 wraps to 0. Otherwise the line number holds.
- R3: For line L, each column's bit is bit L[2:0] of the byte at page L[5:3] and that column. A bit of 1 is a lit pixel.
- R4: The fetched row is copied into the output latch only on a line-clock rising edge. Between rising edges the outputs do not follow RAM contents.
- R5: Segment k (0-based) is `seg_code[2k+1:2k]`. With `mirror_in` high, segment k shows column k. With `mirror_in` low, segment k shows column 63-k.
- R6: The codes are 00 = V0, 01 = V2, 10 = V3 and 11 = V5. With the alternation phase low, a lit pixel gives 00 and an unlit one gives 01. With the phase high, a lit pixel gives 11 and an unlit one gives 10.
- R7: When the sampled display state is off, or while `rst_n` is low, every segment carries its non-select code (01 for phase low, 10 for phase high), whatever the RAM holds.
- R8: `disp_on_in` takes effect only at the next line-clock rising edge. A change between edges leaves the outputs unchanged.
- R9: After a line-clock fall, the fetch issues 64 reads on consecutive cycles for columns 0 to 63 of the current page. It expects read data one cycle after `ram_rd_en`.
- R10: Out of reset the line number is 0, the latch is clear, the display is off and the phase is low, so every code is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| frame_in | input | 1 | Asynchronous frame marker |
| line_clk_in | input | 1 | Asynchronous line clock |
| alt_in | input | 1 | Asynchronous alternation phase |
| mirror_in | input | 1 | Static column order select |
| start_line_in | input | 6 | Scroll start line from host |
| disp_on_in | input | 1 | Display-on request from host |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_page | output | 3 | RAM page address |
| ram_col | output | 6 | RAM column address |
| ram_data_in | input | 8 | RAM read data, one cycle after strobe |
| seg_code | output | 128 | 2-bit level code per segment |

## Verification
The frame preset and the line-clock increment can land in the same cycle. The bench provokes this by holding the frame marker high across a line-clock fall. It then checks that the displayed row is the start line, not the start line plus one, and that the following lines count up from it, including across the 63-to-0 wrap. A second overlap is a display-on change that falls between rising edges: the outputs are compared before and after that edge.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_READ  = 2'd1,
        FS_DRAIN = 2'd2
    } fetch_st_t;

    localparam logic [1:0] LVL_V0 = 2'b00;
    localparam logic [1:0] LVL_V2 = 2'b01;
    localparam logic [1:0] LVL_V3 = 2'b10;
    localparam logic [1:0] LVL_V5 = 2'b11;
endpackage

// File: rtl/seg_scan_sync.sv
module seg_scan_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~prev_q;
    assign fall_o  = ~sync_q & prev_q;
endmodule

// File: rtl/seg_scan_linecnt.sv
module seg_scan_linecnt #(
    parameter int LINE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              step_i,
    input  logic [LINE_W-1:0] start_i,
    output logic [LINE_W-1:0] line_o
);
    logic [LINE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (frame_i) cnt_q <= start_i;
        else if (step_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign line_o = cnt_q;

    // R1
    preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> (line_o == $past(start_i)));
    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !frame_i) |=> (line_o == LINE_W'($past(line_o) + 1'b1)));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !frame_i) |=> $stable(line_o));
endmodule

// File: rtl/seg_scan_fetch.sv
module seg_scan_fetch
    import seg_scan_pkg::*;
#(
    parameter int COLS   = 64,
    parameter int LINE_W = 6,
    parameter int BYTE_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [LINE_W-1:0]              line_i,
    output logic                           rd_en_o,
    output logic [LINE_W-$clog2(BYTE_W)-1:0] rd_page_o,
    output logic [$clog2(COLS)-1:0]        rd_col_o,
    input  logic [BYTE_W-1:0]              rd_data_i,
    output logic [COLS-1:0]                row_o
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam int COL_W = $clog2(COLS);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    fetch_st_t        state_q, state_d;
    logic [COL_W-1:0] col_q;
    logic             vld_q;
    logic [COL_W-1:0] ret_col_q;
    logic [BIT_W-1:0] ret_bit_q;
    logic [COLS-1:0]  row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (start_i) state_d = FS_READ;
            FS_READ:  if (start_i) state_d = FS_READ;
                      else if (col_q == LAST_COL) state_d = FS_DRAIN;
            FS_DRAIN: state_d = start_i ? FS_READ : FS_IDLE;
            default:  state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  col_q <= '0;
        else if (start_i)            col_q <= '0;
        else if (state_q == FS_READ) col_q <= (col_q == LAST_COL) ? '0 : col_q + 1'b1;
    end

    always_comb begin
        rd_en_o   = (state_q == FS_READ);
        rd_page_o = line_i[LINE_W-1:BIT_W];
        rd_col_o  = col_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q     <= 1'b0;
            ret_col_q <= '0;
            ret_bit_q <= '0;
            row_q     <= '0;
        end else begin
            vld_q     <= rd_en_o;
            ret_col_q <= col_q;
            ret_bit_q <= line_i[BIT_W-1:0];
            if (vld_q) row_q[ret_col_q] <= rd_data_i[ret_bit_q];
        end
    end

    assign row_o = row_q;

    // R9
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && !start_i && rd_col_o != LAST_COL) |=>
            (rd_en_o && rd_col_o == COL_W'($past(rd_col_o) + 1'b1)));
    // R9
    fetch_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (rd_en_o && rd_col_o == '0));
    // R9
    fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_o && !start_i) |=> !rd_en_o);
endmodule

// File: rtl/seg_scan_drive.sv
module seg_scan_drive
    import seg_scan_pkg::*;
#(
    parameter int COLS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_i,
    input  logic              on_req_i,
    input  logic              alt_i,
    input  logic              mirror_i,
    input  logic [COLS-1:0]   row_i,
    output logic [2*COLS-1:0] code_o
);
    logic [COLS-1:0] seg_q;
    logic            on_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= '0;
            on_q  <= 1'b0;
        end else if (latch_i) begin
            seg_q <= row_i;
            on_q  <= on_req_i;
        end
    end

    for (genvar k = 0; k < COLS; k++) begin : g_seg
        logic lit;
        assign lit = on_q & (mirror_i ? seg_q[k] : seg_q[COLS-1-k]);
        always_comb begin
            unique case ({alt_i, lit})
                2'b01:   code_o[2*k +: 2] = LVL_V0;
                2'b00:   code_o[2*k +: 2] = LVL_V2;
                2'b10:   code_o[2*k +: 2] = LVL_V3;
                default: code_o[2*k +: 2] = LVL_V5;
            endcase
        end
        // R7
        off_nonsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !on_q |-> (code_o[2*k +: 2] == LVL_V2 || code_o[2*k +: 2] == LVL_V3));
    end

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_i |=> ($stable(seg_q) && $stable(on_q)));
endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top #(
    parameter int COLS   = 64,
    parameter int LINE_W = 6,
    parameter int BYTE_W = 8,
    localparam int PG_W  = LINE_W - $clog2(BYTE_W),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_in,
    input  logic              line_clk_in,
    input  logic              alt_in,
    input  logic              mirror_in,
    input  logic [LINE_W-1:0] start_line_in,
    input  logic              disp_on_in,
    output logic              ram_rd_en,
    output logic [PG_W-1:0]   ram_page,
    output logic [COL_W-1:0]  ram_col,
    input  logic [BYTE_W-1:0] ram_data_in,
    output logic [2*COLS-1:0] seg_code
);
    logic [2:0]        lvl, rise, fall;
    logic [LINE_W-1:0] line;
    logic [COLS-1:0]   row;

    seg_scan_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({alt_in, line_clk_in, frame_in}),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    seg_scan_linecnt #(.LINE_W(LINE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .frame_i(lvl[0]), .step_i(fall[1]),
        .start_i(start_line_in), .line_o(line)
    );

    seg_scan_fetch #(.COLS(COLS), .LINE_W(LINE_W), .BYTE_W(BYTE_W)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .start_i(fall[1]), .line_i(line),
        .rd_en_o(ram_rd_en), .rd_page_o(ram_page), .rd_col_o(ram_col),
        .rd_data_i(ram_data_in), .row_o(row)
    );

    seg_scan_drive #(.COLS(COLS)) u_drv (
        .clk(clk), .rst_n(rst_n),
        .latch_i(rise[1]), .on_req_i(disp_on_in),
        .alt_i(lvl[2]), .mirror_i(mirror_in),
        .row_i(row), .code_o(seg_code)
    );
endmodule

// File: tb/sim_seg_scan_top.sv
`timescale 1ns/1ps
module sim_seg_scan_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frm = 1'b0, cl = 1'b1, m = 1'b0, adc = 1'b1, on_req = 1'b0;
    logic [5:0]   start = '0;
    logic         rd_en;
    logic [2:0]   page;
    logic [5:0]   col;
    logic [7:0]   rdata = '0;
    logic [127:0] codes;
    logic [7:0]   mem [0:511];

    int total = 0, bad = 0;
    int exp_line = 0;
    bit exp_on = 1'b0;

    always #5 clk = ~clk;

    seg_scan_top u0 (
        .clk(clk), .rst_n(rst_n), .frame_in(frm), .line_clk_in(cl),
        .alt_in(m), .mirror_in(adc), .start_line_in(start),
        .disp_on_in(on_req), .ram_rd_en(rd_en), .ram_page(page),
        .ram_col(col), .ram_data_in(rdata), .seg_code(codes)
    );

    always @(posedge clk) if (rd_en) rdata <= mem[{page, col}];

    function automatic logic [127:0] expect_codes(int line, bit on, bit ph, bit mir);
        logic [127:0] r;
        for (int k = 0; k < 64; k++) begin
            int c = mir ? k : 63 - k;
            bit pix = on & mem[(line / 8) * 64 + c][line % 8];
            r[2*k +: 2] = ph ? (pix ? 2'b11 : 2'b10) : (pix ? 2'b00 : 2'b01);
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_line(bit with_frame);
        if (with_frame) begin
            frm = 1'b1;
            repeat (6) @(negedge clk);
        end
        cl = 1'b0;
        repeat (100) @(negedge clk);
        exp_line = with_frame ? int'(start) : (exp_line + 1) % 64;
        cl = 1'b1;
        exp_on = on_req;
        repeat (8) @(negedge clk);
        if (with_frame) begin
            frm = 1'b0;
            repeat (6) @(negedge clk);
        end
    endtask

    initial begin
        #1_500_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [127:0] held;
        void'($urandom(32'd2024));
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        repeat (4) @(negedge clk);
        // R10 / R7: non-select during and after reset
        chk("R7 in reset", codes, {64{2'b01}});
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10 reset state", codes, {64{2'b01}});

        // R1 R3 R5 R6: first frame, start line 0
        on_req = 1'b1;
        start = 6'd0;
        do_line(1'b1);
        chk("R1 frame preset line 0", codes, expect_codes(exp_line, exp_on, m, adc));
        // R2 R3: lines cross the page boundary
        for (int i = 0; i < 10; i++) begin
            do_line(1'b0);
            chk("R2 R3 line step", codes, expect_codes(exp_line, exp_on, m, adc));
        end

        // R6: phase high
        m = 1'b1;
        repeat (10) @(negedge clk);
        chk("R6 phase high", codes, expect_codes(exp_line, exp_on, m, adc));
        // R5: mirrored order
        adc = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 mirror low", codes, expect_codes(exp_line, exp_on, m, adc));

        // R8: on/off change between edges does nothing
        held = codes;
        on_req = 1'b0;
        repeat (30) @(negedge clk);
        chk("R8 off before edge", codes, held);
        do_line(1'b0);
        chk("R7 display off", codes, {64{2'b10}});
        chk("R7 display off model", codes, expect_codes(exp_line, 1'b0, m, adc));
        on_req = 1'b1;
        repeat (30) @(negedge clk);
        chk("R8 on before edge", codes, {64{2'b10}});

        // R1 R2: frame overlapping fall, wrap 63 to 0
        start = 6'd62;
        m = 1'b0;
        do_line(1'b1);
        chk("R1 preset 62 over fall", codes, expect_codes(62, 1'b1, m, adc));
        for (int i = 0; i < 3; i++) begin
            do_line(1'b0);
            chk("R2 wrap", codes, expect_codes(exp_line, exp_on, m, adc));
        end

        // R4: RAM edit between edges leaves output held
        held = codes;
        for (int i = 0; i < 64; i++) mem[(exp_line / 8) * 64 + i] = ~mem[(exp_line / 8) * 64 + i];
        repeat (200) @(negedge clk);
        chk("R4 hold", codes, held);

        // R9 R3: random mix
        for (int i = 0; i < 40; i++) begin
            m = 1'($urandom);
            adc = 1'($urandom);
            on_req = ($urandom % 4) != 0;
            if ($urandom % 5 == 0) begin
                start = 6'($urandom);
                do_line(1'b1);
            end else begin
                do_line(1'b0);
            end
            repeat (3) @(negedge clk);
            chk("R9 random line", codes, expect_codes(exp_line, exp_on, m, adc));
        end

        // R7: reset mid-run
        m = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 reset mid-run", codes, {64{2'b01}});
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule